// File: doc/BRIEF.md
# Power-up Reset and Clock-Settling Sequencer

This block produces the chip-wide internal reset that follows a supply ramp or an external reset. A power-on pulse starts a two-stage wait. First the block holds reset for a fixed power-on interval of 2^17 oscillator clocks. It then waits a longer 2^18-clock interval so that the oscillator can settle. Only after that interval does it enable the internal operation clocks. The internal reset is released once both waits have run out and the external reset pin, seen through a synchronizer, is high.

A one-cycle clear strobe marks the end of the power-on wait. Registers that only a power-on may initialise use it as their clear. While the sequence runs, a port-mode output tells the I/O ring what state to take. The pads float when the external pin is low. They carry no defined value when the pin is high. An external reset that arrives while the block is running repeats the settling wait only if the oscillator had been stopped. Otherwise it gives a short reset of a few clocks and leaves the clocks running.

Both wait lengths, the short reset length and the synchronizer depth are parameters.

Top module: `por_osc_sequencer`

## Requirements
- R1: After the last clock edge with `por_i` high, reset stays asserted and `clk_en_o` stays low for 2^POR_BITS clocks of power-on wait.
- R2: The settling wait of 2^OSC_BITS clocks follows directly. `clk_en_o` stays low through it and goes high on the clock that ends it. It never goes low while reset is released.
- R3: `por_clr_o` is high for exactly one clock, on the clock that ends the power-on wait. It never comes from an external reset.
- R4: While `rst_int_o` is high, `port_mode_o` is 2'b01 (pads floating) when the synchronized pin is low and 2'b10 (value undefined) when it is high. While reset is released it is 2'b00 (normal drive).
- R5: `rst_int_o` is released only after every wait has expired and the synchronized pin is high. The release comes one clock after both conditions hold.
- R6: The synchronizer on `ext_rst_n_i` clears at once when the pin goes low. After the pin returns high, the sequencer sees it high only after SYNC_STAGES rising edges, so reset ends SYNC_STAGES+1 clocks after the release when the waits are already over.
- R7: An external reset taken from the running state with `osc_stop_i` high runs only the settling wait. `clk_en_o` is low for exactly 2^OSC_BITS clocks, and there is no `por_clr_o` pulse.
- R8: An external reset taken from the running state with `osc_stop_i` low holds reset for SHORT_CYCLES clocks, followed by the release step of R5, and `clk_en_o` stays high throughout.
- R9: Holding the pin low during the power-on or settling wait neither restarts nor lengthens either wait. It only delays the release.
- R10: A `por_i` pulse during any phase restarts the sequence from the start of the power-on wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on indication, active high, sampled on the clock; acts as the block's synchronous reset |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| osc_stop_i | input | 1 | High when the oscillator was halted before an external reset |
| rst_int_o | output | 1 | Internal reset, active high, registered |
| clk_en_o | output | 1 | Enable for the internal operation clocks |
| por_clr_o | output | 1 | One-cycle clear for registers that only power-on initialises |
| port_mode_o | output | 2 | Port state: 00 normal, 01 floating, 10 undefined |

## Verification
The hardest situation to reach is a second event arriving while a wait is in progress. This covers a power-on pulse landing in the middle of the settling wait, and the pin falling during the power-on wait. Either one must leave the wait lengths exactly as they were, or restart them cleanly. The bench reaches these cases by running with shortened wait parameters. It places its pulses at counted cycle offsets from a known restart point, so each one falls inside a chosen wait. It then measures the strobe and clock-enable timing from that restart point. It also follows the external-reset branches twice, with the oscillator-stopped input at each value. A behavioural model that runs alongside predicts every output on every clock.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_SETTLE = 3'd1,
    ST_SHORT  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;

  localparam logic [1:0] PM_RUN   = 2'b00;
  localparam logic [1:0] PM_HIZ   = 2'b01;
  localparam logic [1:0] PM_UNDEF = 2'b10;

endpackage

// File: rtl/psr_pin_sync.sv
module psr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;

  // clear on the pin's falling edge, fill with ones on the clock
  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/psr_wait_timer.sv
module psr_wait_timer #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (clear)      cnt_q <= '0;
    else if (!done) cnt_q <= cnt_q + 1'b1;
  end

  // R1: the count never runs past the limit of the current wait
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (clear)
    cnt_q <= limit);
endmodule

// File: rtl/psr_seq_fsm.sv
module psr_seq_fsm
  import psr_pkg::*;
#(
  parameter int POR_BITS     = 17,
  parameter int OSC_BITS     = 18,
  parameter int SHORT_CYCLES = 4,
  parameter int CW           = 18
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          pin_hi_i,
  input  logic          osc_stop_i,
  input  logic          done_i,
  output logic          clear_o,
  output logic [CW-1:0] limit_o,
  output logic          rst_int_o,
  output logic          clk_en_o,
  output logic          por_clr_o,
  output logic [1:0]    port_mode_o
);
  localparam logic [CW-1:0] LIM_POR   = CW'((64'd1 << POR_BITS) - 64'd1);
  localparam logic [CW-1:0] LIM_OSC   = CW'((64'd1 << OSC_BITS) - 64'd1);
  localparam logic [CW-1:0] LIM_SHORT = CW'(SHORT_CYCLES - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (por_i) begin
      state_d = ST_POR;
    end else begin
      unique case (state_q)
        ST_POR:    if (done_i) state_d = ST_SETTLE;
        ST_SETTLE: if (done_i) state_d = ST_HOLD;
        ST_SHORT:  if (done_i) state_d = ST_HOLD;
        ST_HOLD:   if (pin_hi_i) state_d = ST_RUN;
        ST_RUN:    if (!pin_hi_i) state_d = osc_stop_i ? ST_SETTLE : ST_SHORT;
        default:   state_d = ST_POR;
      endcase
    end
  end

  assign clear_o = por_i || (state_d != state_q);

  always_comb begin
    unique case (state_q)
      ST_POR:    limit_o = LIM_POR;
      ST_SETTLE: limit_o = LIM_OSC;
      ST_SHORT:  limit_o = LIM_SHORT;
      default:   limit_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    state_q     <= state_d;
    rst_int_o   <= (state_d != ST_RUN);
    clk_en_o    <= !((state_d == ST_POR) || (state_d == ST_SETTLE));
    por_clr_o   <= !por_i && (state_q == ST_POR) && (state_d == ST_SETTLE);
    port_mode_o <= (state_d != ST_RUN) ? (pin_hi_i ? PM_UNDEF : PM_HIZ) : PM_RUN;
  end

  // R3: the clear strobe lasts one clock and only ends a power-on wait
  p_clr_pulse_r3: assert property (@(posedge clk) disable iff (por_i)
    por_clr_o |=> !por_clr_o);
  p_clr_source_r3: assert property (@(posedge clk) disable iff (por_i)
    por_clr_o |-> $past(state_q) == ST_POR);
  // R2: clocks run whenever reset is released
  p_released_clk_r2: assert property (@(posedge clk) disable iff (por_i)
    !rst_int_o |-> clk_en_o);
  // R4: normal port drive exactly when reset is released
  p_port_run_r4: assert property (@(posedge clk) disable iff (por_i)
    !rst_int_o |-> port_mode_o == PM_RUN);
  // R5: release only follows a high synchronized pin
  p_release_pin_r5: assert property (@(posedge clk) disable iff (por_i)
    $fell(rst_int_o) |-> $past(pin_hi_i));
  // R8: the short reset keeps the clocks running
  p_short_clk_r8: assert property (@(posedge clk) disable iff (por_i)
    (state_q == ST_SHORT) |-> clk_en_o);
  // R7: clocks are gated throughout a settling wait
  p_settle_noclk_r7: assert property (@(posedge clk) disable iff (por_i)
    (state_q == ST_SETTLE) |-> !clk_en_o);
endmodule

// File: rtl/por_osc_sequencer.sv
module por_osc_sequencer #(
  parameter int POR_BITS     = 17,
  parameter int OSC_BITS     = 18,
  parameter int SHORT_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_osc_i,
  input  logic       por_i,
  input  logic       ext_rst_n_i,
  input  logic       osc_stop_i,
  output logic       rst_int_o,
  output logic       clk_en_o,
  output logic       por_clr_o,
  output logic [1:0] port_mode_o
);
  localparam int SW  = $clog2(SHORT_CYCLES + 1);
  localparam int CW0 = (OSC_BITS > POR_BITS) ? OSC_BITS : POR_BITS;
  localparam int CW  = (CW0 > SW) ? CW0 : SW;

  logic          pin_hi;
  logic          tmr_clear;
  logic          tmr_done;
  logic [CW-1:0] tmr_limit;

  psr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_osc_i),
    .pin_n   (ext_rst_n_i),
    .level_o (pin_hi)
  );

  psr_wait_timer #(.CW(CW)) u_timer (
    .clk   (clk_osc_i),
    .clear (tmr_clear),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  psr_seq_fsm #(
    .POR_BITS     (POR_BITS),
    .OSC_BITS     (OSC_BITS),
    .SHORT_CYCLES (SHORT_CYCLES),
    .CW           (CW)
  ) u_fsm (
    .clk         (clk_osc_i),
    .por_i       (por_i),
    .pin_hi_i    (pin_hi),
    .osc_stop_i  (osc_stop_i),
    .done_i      (tmr_done),
    .clear_o     (tmr_clear),
    .limit_o     (tmr_limit),
    .rst_int_o   (rst_int_o),
    .clk_en_o    (clk_en_o),
    .por_clr_o   (por_clr_o),
    .port_mode_o (port_mode_o)
  );

  // R6: a low pin is never seen as high by the sequencer
  p_pin_low_r6: assert property (@(posedge clk_osc_i) disable iff (por_i)
    !ext_rst_n_i |-> !pin_hi);
endmodule

// File: tb/por_osc_sequencer_bench.sv
`timescale 1ns/1ps
module por_osc_sequencer_bench;
  localparam int P = 4;
  localparam int O = 5;
  localparam int SC = 3;
  localparam int SY = 2;

  logic clk = 1'b0;
  logic por_i = 1'b1;
  logic ext_rst_n_i = 1'b1;
  logic osc_stop_i = 1'b0;
  logic rst_int_o, clk_en_o, por_clr_o;
  logic [1:0] port_mode_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  por_osc_sequencer #(.POR_BITS(P), .OSC_BITS(O), .SHORT_CYCLES(SC), .SYNC_STAGES(SY))
    u_por_osc_sequencer (
      .clk_osc_i(clk), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i), .osc_stop_i(osc_stop_i),
      .rst_int_o(rst_int_o), .clk_en_o(clk_en_o), .por_clr_o(por_clr_o),
      .port_mode_o(port_mode_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 power-on, 1 settle, 2 short, 3 hold, 4 run
  int ph = 0, rem = 0, hc = 0;
  bit mvalid = 0, m_rst = 1, m_clk = 0, m_clr = 0;
  int m_pm = 0;

  always @(posedge clk) begin
    bit seen;
    seen = ext_rst_n_i && (hc >= SY);
    hc = ext_rst_n_i ? hc + 1 : 0;
    m_clr = 0;
    if (por_i) begin
      ph = 0; rem = 2**P; mvalid = 1;
    end else begin
      case (ph)
        0: begin rem--; if (rem == 0) begin ph = 1; rem = 2**O; m_clr = 1; end end
        1: begin rem--; if (rem == 0) ph = 3; end
        2: begin rem--; if (rem == 0) ph = 3; end
        3: if (seen) ph = 4;
        default: if (!seen) begin
          if (osc_stop_i) begin ph = 1; rem = 2**O; end
          else begin ph = 2; rem = SC; end
        end
      endcase
    end
    m_rst = (ph != 4);
    m_clk = !(ph == 0 || ph == 1);
    m_pm = m_rst ? (seen ? 2 : 1) : 0;
  end

  always @(negedge clk) begin
    if (mvalid && !finished) begin
      chk(rst_int_o == m_rst, "R5 model rst", rst_int_o, m_rst);
      chk(clk_en_o == m_clk, "R2 model clk_en", clk_en_o, m_clk);
      chk(por_clr_o == m_clr, "R3 model por_clr", por_clr_o, m_clr);
      chk(port_mode_o == 2'(m_pm), "R4 model port_mode", port_mode_o, m_pm);
    end
  end

  task automatic por_pulse();
    por_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, m, lo, hi;
    bit sawclr;
    repeat (4) @(negedge clk);
    // R1 reset state while power-on is asserted
    chk(rst_int_o == 1'b1, "R1 reset rst", rst_int_o, 1);
    chk(clk_en_o == 1'b0, "R1 reset clk_en", clk_en_o, 0);
    chk(por_clr_o == 1'b0, "R1 reset por_clr", por_clr_o, 0);
    chk(port_mode_o == 2'b10, "R4 reset port undefined", port_mode_o, 2);
    por_i = 1'b0;

    // Scenario A: plain power-up
    n = 0;
    do begin @(negedge clk); n++; end while (!por_clr_o && n < 1000);
    chk(n == 2**P, "R1 power-on wait length", n, 2**P);
    m = 0;
    do begin @(negedge clk); m++; end while (!clk_en_o && m < 1000);
    chk(m == 2**O, "R2 settling wait length", m, 2**O);
    chk(rst_int_o == 1'b1 && port_mode_o == 2'b10, "R4 undefined before release", port_mode_o, 2);
    @(negedge clk);
    chk(rst_int_o == 1'b0, "R5 release one clock later", rst_int_o, 0);
    chk(port_mode_o == 2'b00, "R4 normal drive", port_mode_o, 0);

    // Scenario B: pin held low across the waits
    por_pulse();
    n = 0;
    do begin @(negedge clk); n++; if (n == 3) ext_rst_n_i = 1'b0; end
    while (!por_clr_o && n < 1000);
    chk(n == 2**P, "R9 power-on wait not stretched", n, 2**P);
    m = 0;
    do begin @(negedge clk); m++; end while (!clk_en_o && m < 1000);
    chk(m == 2**O, "R9 settling wait not stretched", m, 2**O);
    repeat (5) @(negedge clk);
    chk(rst_int_o == 1'b1, "R5 held by low pin", rst_int_o, 1);
    chk(port_mode_o == 2'b01, "R4 floating with pin low", port_mode_o, 1);
    ext_rst_n_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (rst_int_o && n < 1000);
    chk(n == SY + 1, "R6 release latency", n, SY + 1);

    // Scenario C: external reset with oscillator stopped
    repeat (3) @(negedge clk);
    osc_stop_i = 1'b1;
    ext_rst_n_i = 1'b0;
    @(negedge clk);
    ext_rst_n_i = 1'b1;
    osc_stop_i = 1'b0;
    lo = clk_en_o ? 0 : 1;
    sawclr = por_clr_o;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!clk_en_o) lo++;
      if (por_clr_o) sawclr = 1;
    end while (rst_int_o && n < 1000);
    chk(lo == 2**O, "R7 settle-only gated cycles", lo, 2**O);
    chk(!sawclr, "R7 no power-on clear", sawclr, 0);

    // Scenario D: external reset with oscillator running
    repeat (3) @(negedge clk);
    ext_rst_n_i = 1'b0;
    @(negedge clk);
    ext_rst_n_i = 1'b1;
    hi = rst_int_o ? 1 : 0;
    lo = clk_en_o ? 0 : 1;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (rst_int_o) hi++;
      if (!clk_en_o) lo++;
    end while (rst_int_o && n < 1000);
    // short wait of SC clocks, then one release clock
    chk(hi == SC + 1, "R8 short reset length", hi, SC + 1);
    chk(lo == 0, "R8 clocks kept running", lo, 0);

    // Scenario E: power-on again in the middle of a settling wait
    repeat (2) @(negedge clk);
    por_pulse();
    repeat (2**P + 5) @(negedge clk);
    chk(clk_en_o == 1'b0, "R10 inside settle", clk_en_o, 0);
    por_pulse();
    chk(clk_en_o == 1'b0 && rst_int_o == 1'b1, "R10 restart state", rst_int_o, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!por_clr_o && n < 1000);
    chk(n == 2**P, "R10 restarted power-on wait", n, 2**P);
    m = 0;
    do begin @(negedge clk); m++; end while (rst_int_o && m < 1000);
    chk(m == 2**O + 1, "R10 full settle after restart", m, 2**O + 1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule